// File: doc/BRIEF.md
# Prescaled Ramp Counter

This block turns a stream of single-cycle trigger pulses into a bounded ramp. An 8-bit prescaler first divides the trigger pulses by a programmable factor. Each prescaled tick then moves a 16-bit counter that runs between a programmable low bound and a programmable high bound.

In sawtooth shape the counter climbs from the low bound to the high bound and then jumps back to the low bound. In triangle shape it climbs to the high bound, turns around and descends to the low bound. The block reports the counter value, a pulse for every counter step, and a pulse when a counting period completes.

Four single-cycle commands control the block: start, stop, update and reset. The first start while idle loads the configuration immediately and arms counting. After that, the configuration is reloaded by update, by reset, or automatically at the end of each period. This lets software change the waveform on a period boundary without glitches.

Top module: `ramp_timer`

## Requirements
- R1: After reset `countOut` is 0, `stepEvt` and `endEvt` are 0, and the block is idle.
- R2: With prescale value P, one tick is produced for every P+1 accepted trigger pulses. The tick shows as `stepEvt` high for one cycle, in the cycle after the clock edge that sampled the (P+1)-th pulse.
- R3: With prescale value 0, every accepted trigger pulse produces a tick.
- R4: With `cfgSaw`=1 (sawtooth), each tick adds one to the count until the count equals the high bound. The tick after that sets the count to the low bound.
- R5: With `cfgSaw`=0 (triangle), the count climbs by one per tick up to the high bound and then descends by one per tick. The tick that brings it back to the low bound ends the period, and the next period starts climbing again.
- R6: `endEvt` pulses together with `stepEvt` on the tick that ends a period, and at that moment `countOut` equals the low bound.
- R7: A start command while idle loads all configuration, sets the count to `cfgLow` at the next edge and makes the block active. A stop command wins over a start in the same cycle.
- R8: A stop command makes the block idle. While idle, trigger pulses and reset commands leave `countOut` unchanged and produce no `stepEvt`.
- R9: A start command while active changes neither the count nor the loaded configuration.
- R10: An update command while active reloads the prescale value, the bounds and the shape, but does not move the count.
- R11: A reset command while active reloads the configuration, sets the count to `cfgLow` and clears the prescaler, and the block stays active.
- R12: At the end of each period the configuration inputs are reloaded, and the count restarts at the new low bound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| evtIn | input | 1 | Trigger pulse, one per cycle high |
| cmdStart | input | 1 | Start command pulse |
| cmdStop | input | 1 | Stop command pulse |
| cmdUpdate | input | 1 | Configuration reload pulse |
| cmdReset | input | 1 | Counter restart pulse |
| cfgPresc | input | 8 | Prescale value P (divide by P+1) |
| cfgLow | input | 16 | Low bound of the count |
| cfgHigh | input | 16 | High bound of the count |
| cfgSaw | input | 1 | 1 = sawtooth, 0 = triangle |
| countOut | output | 16 | Current count |
| stepEvt | output | 1 | Pulse for each counter step |
| endEvt | output | 1 | Pulse at period completion |

## Verification
A wrong prescaler count changes the spacing of `stepEvt` pulses from the first divided tick onward, so it is visible within P+1 trigger pulses. A wrong direction flag or a wrong bound comparison makes `countOut` leave the expected ramp on the very tick where the turn or wrap should occur. A shadow register loaded at the wrong moment shows up at the next period end or command, as a count that restarts at the wrong bound.

// File: rtl/ramp_timer_pkg.sv
package ramp_timer_pkg;
  typedef struct packed {
    logic loadCfg;   // copy configuration inputs into shadows
    logic restart;   // count to low bound, prescaler cleared, direction up
    logic countEn;   // a trigger pulse is accepted this cycle
  } ctlStrobe_t;
endpackage

// File: rtl/ramp_timer_ctrl.sv
module ramp_timer_ctrl
  import ramp_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       evtIn,
  input  logic       cmdStart,
  input  logic       cmdStop,
  input  logic       cmdUpdate,
  input  logic       cmdReset,
  output ctlStrobe_t strobe,
  output logic       active
);
  logic firstStart;
  logic resetHit;

  assign firstStart = cmdStart && !active && !cmdStop;
  assign resetHit   = cmdReset && active;

  always_comb begin
    strobe.restart = firstStart || resetHit;
    strobe.loadCfg = firstStart || resetHit || (active && cmdUpdate);
    strobe.countEn = active && evtIn && !cmdReset;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           active <= 1'b0;
    else if (cmdStop)    active <= 1'b0;
    else if (firstStart) active <= 1'b1;
  end

  AST_STOP_IDLES: assert property (@(posedge clk) disable iff (!rstN)
    cmdStop |=> !active); // R8

  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStart && !cmdStop) |=> active); // R7
endmodule

// File: rtl/ramp_timer_dp.sv
module ramp_timer_dp
  import ramp_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobe,
  input  logic [PSC_W-1:0] cfgPresc,
  input  logic [CNT_W-1:0] cfgLow,
  input  logic [CNT_W-1:0] cfgHigh,
  input  logic             cfgSaw,
  output logic [CNT_W-1:0] countOut,
  output logic             stepEvt,
  output logic             endEvt
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [PSC_W-1:0] PONE = PSC_W'(1);

  logic [PSC_W-1:0] pscShadow, pscCnt;
  logic [CNT_W-1:0] lowShadow, highShadow, count, nextCount;
  logic             sawShadow, dirDown, nextDir, atEnd, tick;

  assign tick     = strobe.countEn && (pscCnt >= pscShadow);
  assign countOut = count;

  always_comb begin
    nextCount = count;
    nextDir   = dirDown;
    atEnd     = 1'b0;
    if (sawShadow) begin
      if (count >= highShadow) atEnd = 1'b1;
      else                     nextCount = count + ONE;
    end else if (!dirDown) begin
      if (count >= highShadow) begin
        if (highShadow <= lowShadow) atEnd = 1'b1;
        else begin
          nextCount = count - ONE;
          nextDir   = 1'b1;
          if (count - ONE <= lowShadow) atEnd = 1'b1;
        end
      end else nextCount = count + ONE;
    end else begin
      if (count <= lowShadow + ONE) atEnd = 1'b1;
      else                          nextCount = count - ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pscShadow  <= '0;
      lowShadow  <= '0;
      highShadow <= '0;
      sawShadow  <= 1'b0;
    end else if (strobe.loadCfg || (tick && atEnd)) begin
      pscShadow  <= cfgPresc;
      lowShadow  <= cfgLow;
      highShadow <= cfgHigh;
      sawShadow  <= cfgSaw;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      dirDown <= 1'b0;
      pscCnt  <= '0;
      stepEvt <= 1'b0;
      endEvt  <= 1'b0;
    end else if (strobe.restart) begin
      count   <= cfgLow;
      dirDown <= 1'b0;
      pscCnt  <= '0;
      stepEvt <= 1'b0;
      endEvt  <= 1'b0;
    end else begin
      stepEvt <= tick;
      endEvt  <= tick && atEnd;
      if (strobe.countEn) pscCnt <= tick ? '0 : pscCnt + PONE;
      if (tick) begin
        if (atEnd) begin
          count   <= cfgLow;
          dirDown <= 1'b0;
        end else begin
          count   <= nextCount;
          dirDown <= nextDir;
        end
      end
    end
  end

  AST_END_AT_LOW: assert property (@(posedge clk) disable iff (!rstN)
    endEvt |-> (count == lowShadow)); // R6

  AST_END_WITH_STEP: assert property (@(posedge clk) disable iff (!rstN)
    endEvt |-> stepEvt); // R6

  AST_STEP_UNIT: assert property (@(posedge clk) disable iff (!rstN)
    (stepEvt && !endEvt) |->
      (count == $past(count) + ONE || count == $past(count) - ONE)); // R4

  AST_STEP_NEEDS_TRIGGER: assert property (@(posedge clk) disable iff (!rstN)
    stepEvt |-> $past(strobe.countEn)); // R2

  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(strobe.countEn) && !$past(strobe.restart)) |-> $stable(count)); // R8
endmodule

// File: rtl/ramp_timer.sv
module ramp_timer
  import ramp_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evtIn,
  input  logic             cmdStart,
  input  logic             cmdStop,
  input  logic             cmdUpdate,
  input  logic             cmdReset,
  input  logic [PSC_W-1:0] cfgPresc,
  input  logic [CNT_W-1:0] cfgLow,
  input  logic [CNT_W-1:0] cfgHigh,
  input  logic             cfgSaw,
  output logic [CNT_W-1:0] countOut,
  output logic             stepEvt,
  output logic             endEvt
);
  ctlStrobe_t strobe;
  logic       active;

  ramp_timer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .evtIn(evtIn),
    .cmdStart(cmdStart), .cmdStop(cmdStop),
    .cmdUpdate(cmdUpdate), .cmdReset(cmdReset),
    .strobe(strobe), .active(active)
  );

  ramp_timer_dp #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cfgPresc(cfgPresc), .cfgLow(cfgLow), .cfgHigh(cfgHigh), .cfgSaw(cfgSaw),
    .countOut(countOut), .stepEvt(stepEvt), .endEvt(endEvt)
  );

  AST_IDLE_NO_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !$past(active) |-> !stepEvt); // R8
endmodule

// File: tb/ramp_timer_bench.sv
`timescale 1ns/1ps
module ramp_timer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        evtIn = 1'b0, cmdStart = 1'b0, cmdStop = 1'b0;
  logic        cmdUpdate = 1'b0, cmdReset = 1'b0;
  logic [7:0]  cfgPresc = '0;
  logic [15:0] cfgLow = '0, cfgHigh = '0;
  logic        cfgSaw = 1'b0;
  logic [15:0] countOut;
  logic        stepEvt, endEvt;
  int          total = 0, fails = 0;

  always #2.5 clk = ~clk;

  ramp_timer u_ramp_timer (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .cmdStart(cmdStart),
    .cmdStop(cmdStop), .cmdUpdate(cmdUpdate), .cmdReset(cmdReset),
    .cfgPresc(cfgPresc), .cfgLow(cfgLow), .cfgHigh(cfgHigh), .cfgSaw(cfgSaw),
    .countOut(countOut), .stepEvt(stepEvt), .endEvt(endEvt)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // which: 0 start, 1 stop, 2 update, 3 reset, 4 trigger
  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: cmdStart = 1'b1;
      1: cmdStop = 1'b1;
      2: cmdUpdate = 1'b1;
      3: cmdReset = 1'b1;
      default: evtIn = 1'b1;
    endcase
    @(negedge clk);
    {cmdStart, cmdStop, cmdUpdate, cmdReset, evtIn} = '0;
  endtask

  function automatic int expCount(int lo, int hi, bit saw, int k);
    int d = hi - lo;
    int pos;
    if (saw) return lo + (k % (d + 1));
    pos = k % (2 * d);
    return (pos <= d) ? lo + pos : lo + 2 * d - pos;
  endfunction

  function automatic bit expEnd(int lo, int hi, bit saw, int k);
    int d = hi - lo;
    if (k == 0) return 1'b0;
    return saw ? ((k % (d + 1)) == 0) : ((k % (2 * d)) == 0);
  endfunction

  task automatic sweep(input int p, input int lo, input int hi, input bit saw);
    int per = saw ? (hi - lo + 1) : 2 * (hi - lo);
    int nEv = (2 * per + 1) * (p + 1);
    cfgPresc = 8'(p); cfgLow = 16'(lo); cfgHigh = 16'(hi); cfgSaw = saw;
    pulse(0);
    chk("R7 start loads low", countOut, lo);
    for (int e = 1; e <= nEv; e++) begin
      int k = e / (p + 1);
      bit t = (e % (p + 1)) == 0;
      pulse(4);
      chk(p == 0 ? "R3 step every pulse" : "R2 prescaled step", stepEvt, t);
      chk(saw ? "R4 sawtooth count" : "R5 triangle count", countOut, expCount(lo, hi, saw, k));
      chk("R6 period end", endEvt, t && expEnd(lo, hi, saw, k));
    end
    pulse(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset count", countOut, 0);
    chk("R1 reset step", stepEvt, 0);
    chk("R1 reset end", endEvt, 0);
    rstN = 1'b1;
    pulse(4);
    chk("R1 idle after reset", countOut, 0);

    for (int p = 0; p < 4; p++)
      for (int s = 0; s < 2; s++) begin
        sweep(p, 3, 6, s[0]);
        sweep(p, 0, 1, s[0]);
      end

    // start and stop together: stop wins
    cfgPresc = 0; cfgLow = 9; cfgHigh = 12; cfgSaw = 1;
    @(negedge clk); cmdStart = 1; cmdStop = 1;
    @(negedge clk); cmdStart = 0; cmdStop = 0;
    pulse(4);
    chk("R7 stop beats start step", stepEvt, 0);

    // update keeps count, reloads bounds
    cfgLow = 0; cfgHigh = 9; cfgSaw = 1; cfgPresc = 0;
    pulse(0);
    repeat (3) pulse(4);
    chk("R10 pre-update count", countOut, 3);
    cfgHigh = 4;
    pulse(2);
    chk("R10 update holds count", countOut, 3);
    pulse(4);
    chk("R10 count after update", countOut, 4);
    pulse(4);
    chk("R10 new high wraps", countOut, 0);
    chk("R10 new high end", endEvt, 1);

    // period end reloads new bounds
    cfgLow = 5; cfgHigh = 7;
    repeat (4) pulse(4);
    chk("R12 old range last", countOut, 4);
    pulse(4);
    chk("R12 restart at new low", countOut, 5);
    chk("R12 end at reload", endEvt, 1);
    pulse(4); pulse(4);
    chk("R12 new high reached", countOut, 7);
    pulse(4);
    chk("R12 new range wraps", countOut, 5);

    // start while active ignored
    cfgLow = 11; cfgHigh = 14;
    pulse(0);
    chk("R9 start while active", countOut, 5);
    pulse(4);
    chk("R9 range kept", countOut, 6);

    // reset command: new low, prescaler cleared, still active
    pulse(1);
    cfgLow = 0; cfgHigh = 9; cfgSaw = 1; cfgPresc = 2;
    pulse(0);
    repeat (3) pulse(4);
    chk("R2 first divided tick", countOut, 1);
    repeat (2) pulse(4);
    cfgLow = 2;
    pulse(3);
    chk("R11 reset to low", countOut, 2);
    repeat (2) pulse(4);
    chk("R11 prescaler cleared step", stepEvt, 0);
    chk("R11 prescaler cleared count", countOut, 2);
    pulse(4);
    chk("R11 still active step", stepEvt, 1);
    chk("R11 still active count", countOut, 3);

    // stop: pulses and reset ignored
    pulse(1);
    repeat (3) begin
      pulse(4);
      chk("R8 idle no step", stepEvt, 0);
    end
    cfgLow = 8;
    pulse(3);
    chk("R8 idle reset ignored", countOut, 3);
    pulse(0);
    chk("R7 restart loads low", countOut, 8);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule